// File: doc/BRIEF.md
# Matrix Loop Index Remapper

This block turns the linear step count of a vector loop (0, 1, 2, ... VL-1) into a reordered element index. The loop is treated as a walk over a one-, two- or three-axis array. A 32-bit shape word describes that walk: the axis sizes, the order in which the axes are nested, which axes run backwards, one optional axis to drop from the result, and a constant added to every index. Transposes, rotations, repeat sequences (0 0 0 1 1 1) and modulo sequences (0 1 2 0 1 2) of any size can all be produced. Sizes do not have to be powers of two.

Software loads a shape word and a vector length with a one-cycle start pulse. The consumer then takes one index per cycle through a valid/ready step handshake. The index shown while ready is high is the one for the current step. After VL steps have been taken, the block raises a done flag. Shape words that select the register-indexed variant are not walked; they are only flagged.

Top module: `mtx_index_remap`

## Requirements
- R1: A shape word of all zeros selects linear mode: the index for step k equals k.
- R2: Shape fields are laid out as follows. Bits 5:0, 11:6 and 17:12 hold the x, y and z sizes minus one, so a field value of 0 means one element. An axis's coordinate weight is 1 for x, the x size for y, and the x size times the y size for z. The index is the sum of each coordinate times its weight. Bits 31:30 must be 00.
- R3: Bits 20:18 choose the nesting order, listed from the innermost axis outward: 000 x,y,z; 001 x,z,y; 010 y,x,z; 011 y,z,x; 100 z,x,y; 101 z,y,x. The innermost axis changes on every step, and an outer axis moves only when every axis inside it wraps.
- R4: Bit 21 reverses x, bit 22 reverses y and bit 23 reverses z. A reversed axis starts at its size minus one, counts down to 0 and then wraps back to its size minus one.
- R5: Bits 29:28 drop one axis from the index, chosen by nesting position: 01 innermost, 10 middle, 11 outermost, 00 none. A dropped axis adds nothing to the index and its size is left out of the weights of the axes above it. This gives repeat sequences (innermost dropped) and modulo sequences (outer dropped).
- R6: The 4-bit value in bits 27:24 is added to every index.
- R7: A start whose shape has bits 31:30 = 00 and bits 20:18 = 110 or 111 runs no steps. One cycle later idx_mode_o is 1, done_o is 1 and step_ready_o is 0.
- R8: A step is taken on a clock edge where step_valid_i and step_ready_o are both high. While no step is taken, index_o and step_ready_o stay unchanged.
- R9: Once the VL-th step has been taken, step_ready_o is 0 and done_o is 1 on the next cycle. done_o then stays high until the next start. A VL of 0 gives done on the cycle after start. VL may be anything from 0 to 127. If VL exceeds the number of array elements, the walk wraps and starts over.
- R10: A start pulse takes priority over a step in the same cycle. It reloads every axis from its starting value, even in the middle of a run, and clears done.
- R11: After reset, step_ready_o, done_o and idx_mode_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shape_i | input | 32 | Shape word, captured on start |
| start_i | input | 1 | Start pulse: load shape and VL, reset the walk |
| vlen_i | input | 7 | Number of steps, captured on start |
| step_valid_i | input | 1 | Consumer takes the current index |
| step_ready_o | output | 1 | Walk in progress; index_o is valid |
| index_o | output | 19 | Remapped index for the current step |
| done_o | output | 1 | All VL steps taken |
| idx_mode_o | output | 1 | Last start selected the indexed variant |

## Verification
The checker runs on every cycle and confirms the following. Linear mode tracks its own step count. The index holds steady while no step is taken. done_o arrives exactly one cycle after the last step and never overlaps step_ready_o. Indexed-variant and empty starts finish at once. The actual reordering can only be shown by the bench's directed walks: each of the six nesting orders, reversal, all three drop positions, the offset, and wrap-around at VL 127. Each walk's index sequence is compared with a reference computed by division and remainder. A few hand-written sequences, such as a transpose and a repeat pattern, are also checked.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int SHAPE_W = 32;
  localparam int DIM_W   = 6;
  localparam int OFS_W   = 4;
  localparam int VL_W    = 7;
  localparam int NAX     = 3;
  localparam int AX_W    = 2;
  localparam int WGT_W   = 2 * DIM_W + 1;
  localparam int IDX_W   = NAX * DIM_W + 1;

  typedef logic [DIM_W-1:0] dim_t;
  typedef logic [AX_W-1:0]  ax_t;

  typedef struct packed {
    logic [1:0]       mode;
    logic [1:0]       skip;
    logic [OFS_W-1:0] offset;
    logic [NAX-1:0]   inv;
    logic [2:0]       perm;
    dim_t             zd;
    dim_t             yd;
    dim_t             xd;
  } shape_t;

  localparam ax_t AX_X = 2'd0;
  localparam ax_t AX_Y = 2'd1;
  localparam ax_t AX_Z = 2'd2;
endpackage

// File: rtl/remap_order_dec.sv
module remap_order_dec
  import remap_pkg::*;
(
  input  logic [2:0]        perm_i,
  output ax_t [NAX-1:0]     ord_o,
  output ax_t [NAX-1:0]     pos_o,
  output logic              indexed_o
);
  // ord_o[p]: axis at nesting position p (0 = innermost)
  always_comb begin
    indexed_o = 1'b0;
    case (perm_i)
      3'b000: begin ord_o[0] = AX_X; ord_o[1] = AX_Y; ord_o[2] = AX_Z; end
      3'b001: begin ord_o[0] = AX_X; ord_o[1] = AX_Z; ord_o[2] = AX_Y; end
      3'b010: begin ord_o[0] = AX_Y; ord_o[1] = AX_X; ord_o[2] = AX_Z; end
      3'b011: begin ord_o[0] = AX_Y; ord_o[1] = AX_Z; ord_o[2] = AX_X; end
      3'b100: begin ord_o[0] = AX_Z; ord_o[1] = AX_X; ord_o[2] = AX_Y; end
      3'b101: begin ord_o[0] = AX_Z; ord_o[1] = AX_Y; ord_o[2] = AX_X; end
      default: begin
        ord_o[0] = AX_X; ord_o[1] = AX_Y; ord_o[2] = AX_Z;
        indexed_o = 1'b1;
      end
    endcase
  end

  // inverse map: position of each axis
  always_comb begin
    pos_o = '0;
    for (int p = 0; p < NAX; p++) begin
      pos_o[ord_o[p]] = ax_t'(p);
    end
  end
endmodule

// File: rtl/remap_axis_ctr.sv
module remap_axis_ctr
  import remap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic adv_i,
  input  logic inv_i,
  input  dim_t size_m1_i,
  output dim_t cnt_o,
  output logic at_end_o
);
  dim_t cnt_q;
  dim_t cnt_d;
  dim_t home;
  logic cnt_en;

  assign home     = inv_i ? size_m1_i : '0;
  assign at_end_o = inv_i ? (cnt_q == '0) : (cnt_q == size_m1_i);
  assign cnt_en   = load_i | adv_i;
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = home;
    end else if (adv_i) begin
      if (at_end_o)   cnt_d = home;
      else if (inv_i) cnt_d = cnt_q - DIM_W'(1);
      else            cnt_d = cnt_q + DIM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/remap_index_calc.sv
module remap_index_calc
  import remap_pkg::*;
(
  input  dim_t [NAX-1:0]   ctr_i,
  input  dim_t [NAX-1:0]   size_m1_i,
  input  logic             skip_en_i,
  input  ax_t              skip_ax_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [IDX_W-1:0] index_o
);
  logic [NAX-1:0]   keep;
  logic [WGT_W-1:0] span   [NAX];
  logic [WGT_W-1:0] weight [NAX];
  logic [IDX_W-1:0] term   [NAX];

  always_comb begin
    for (int a = 0; a < NAX; a++) begin
      keep[a] = !(skip_en_i && (skip_ax_i == ax_t'(a)));
    end
  end

  genvar g;
  generate
    for (g = 0; g < NAX; g++) begin : g_axis
      assign span[g] = keep[g] ? (WGT_W'(size_m1_i[g]) + WGT_W'(1)) : WGT_W'(1);
      if (g == 0) begin : g_base
        assign weight[g] = WGT_W'(1);
      end else begin : g_chain
        assign weight[g] = weight[g-1] * span[g-1];
      end
      assign term[g] = keep[g] ? (IDX_W'(ctr_i[g]) * IDX_W'(weight[g])) : '0;
    end
  endgenerate

  assign index_o = IDX_W'(ofs_i) + term[0] + term[1] + term[2];
endmodule

// File: rtl/mtx_index_remap.sv
module mtx_index_remap
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      shape_i,
  input  logic             start_i,
  input  logic [6:0]       vlen_i,
  input  logic             step_valid_i,
  output logic             step_ready_o,
  output logic [18:0]      index_o,
  output logic             done_o,
  output logic             idx_mode_o
);
  shape_t shape_in, shape_q, shape_ld;
  logic [VL_W-1:0] vl_q, cnt_q, cnt_d;
  logic busy_q, busy_d, done_q, done_d, idxm_q, idxm_d;
  logic acc, last, lin, perm_idx, start_idx, skip_en;
  ax_t  skip_ax;
  dim_t [NAX-1:0] size_sel, ctr_val;
  logic [NAX-1:0] inv_sel, at_end, adv;
  ax_t  [NAX-1:0] ord, posof;
  logic [NAX:0]   carry_pos;
  logic [IDX_W-1:0] calc_idx;

  assign shape_in = shape_t'(shape_i);
  // on start the counters load from the incoming word
  assign shape_ld = start_i ? shape_in : shape_q;
  assign size_sel = {shape_ld.zd, shape_ld.yd, shape_ld.xd};
  assign inv_sel  = shape_ld.inv;

  remap_order_dec u_ord (
    .perm_i    (shape_ld.perm),
    .ord_o     (ord),
    .pos_o     (posof),
    .indexed_o (perm_idx)
  );

  assign start_idx = (shape_in.mode == 2'b00) && perm_idx;
  assign acc       = busy_q & step_valid_i & ~start_i;
  assign last      = (cnt_q == (vl_q - VL_W'(1)));

  // ripple carry along the nesting order
  always_comb begin
    carry_pos[0] = acc;
    for (int p = 0; p < NAX; p++) begin
      carry_pos[p+1] = carry_pos[p] & at_end[ord[p]];
    end
    for (int a = 0; a < NAX; a++) begin
      adv[a] = carry_pos[posof[a]];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NAX; g++) begin : g_ctr
      remap_axis_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_i),
        .adv_i     (adv[g]),
        .inv_i     (inv_sel[g]),
        .size_m1_i (size_sel[g]),
        .cnt_o     (ctr_val[g]),
        .at_end_o  (at_end[g])
      );
    end
  endgenerate

  always_comb begin
    skip_en = (shape_q.skip != 2'b00);
    case (shape_q.skip)
      2'b01:   skip_ax = ord[0];
      2'b10:   skip_ax = ord[1];
      2'b11:   skip_ax = ord[2];
      default: skip_ax = AX_X;
    endcase
  end

  remap_index_calc u_calc (
    .ctr_i     (ctr_val),
    .size_m1_i ({shape_q.zd, shape_q.yd, shape_q.xd}),
    .skip_en_i (skip_en),
    .skip_ax_i (skip_ax),
    .ofs_i     (shape_q.offset),
    .index_o   (calc_idx)
  );

  assign lin = (shape_q == '0);

  // control next state
  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = done_q;
    idxm_d = idxm_q;
    if (start_i) begin
      cnt_d  = '0;
      idxm_d = start_idx;
      busy_d = !start_idx && (vlen_i != '0);
      done_d = start_idx || (vlen_i == '0);
    end else if (acc) begin
      cnt_d = cnt_q + VL_W'(1);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q <= '0;
      vl_q    <= '0;
    end else if (start_i) begin
      shape_q <= shape_in;
      vl_q    <= vlen_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idxm_q <= 1'b0;
    end else if (start_i || acc) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      idxm_q <= idxm_d;
    end
  end

  assign step_ready_o = busy_q;
  assign done_o       = done_q;
  assign idx_mode_o   = idxm_q;
  assign index_o      = lin ? IDX_W'(cnt_q) : calc_idx;
endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] shape_i,
  input logic        start_i,
  input logic [6:0]  vlen_i,
  input logic        step_valid_i,
  input logic        step_ready_o,
  input logic [18:0] index_o,
  input logic        done_o,
  input logic        idx_mode_o
);
  logic [VL_W-1:0] c_vl, c_cnt;
  logic c_zero, c_idx_start;

  assign c_idx_start = start_i && (shape_i[31:30] == 2'b00) && (shape_i[20:19] == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_vl   <= '0;
      c_cnt  <= '0;
      c_zero <= 1'b0;
    end else if (start_i) begin
      c_vl   <= vlen_i;
      c_cnt  <= '0;
      c_zero <= (shape_i == '0);
    end else if (step_valid_i && step_ready_o) begin
      c_cnt  <= c_cnt + VL_W'(1);
    end
  end

  assert_linear_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_ready_o && c_zero |-> index_o == IDX_W'(c_cnt));

  assert_indexed_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_idx_start |=> idx_mode_o && done_o && !step_ready_o);

  assert_hold_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_ready_o && !step_valid_i && !start_i |=> $stable(index_o) && step_ready_o);

  assert_last_step_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_ready_o && step_valid_i && !start_i && (c_cnt == c_vl - VL_W'(1)) |=> done_o && !step_ready_o);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  assert_ready_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && step_ready_o));

  assert_empty_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (vlen_i == '0) |=> done_o && !step_ready_o);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (vlen_i != '0) && !c_idx_start |=> step_ready_o && !done_o && !idx_mode_o);
endmodule

bind mtx_index_remap remap_chk u_remap_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shape_i      (shape_i),
  .start_i      (start_i),
  .vlen_i       (vlen_i),
  .step_valid_i (step_valid_i),
  .step_ready_o (step_ready_o),
  .index_o      (index_o),
  .done_o       (done_o),
  .idx_mode_o   (idx_mode_o)
);

// File: tb/test_mtx_index_remap.sv
`timescale 1ns/1ps
module test_mtx_index_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] shape = '0;
  logic        start = 1'b0;
  logic [6:0]  vlen = '0;
  logic        valid = 1'b0;
  logic        ready, done, idxm;
  logic [18:0] index;

  int errors = 0;
  int checks = 0;
  int got [128];

  always #10 clk = ~clk;

  mtx_index_remap i_mtx_index_remap (
    .clk(clk), .rst_n(rst_n), .shape_i(shape), .start_i(start), .vlen_i(vlen),
    .step_valid_i(valid), .step_ready_o(ready), .index_o(index),
    .done_o(done), .idx_mode_o(idxm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int skip, input int ofs, input int inv,
                                     input int perm, input int zd, input int yd, input int xd);
    return {2'b00, 2'(skip), 4'(ofs), 3'(inv), 3'(perm), 6'(zd), 6'(yd), 6'(xd)};
  endfunction

  // reference: decompose the step number by division and remainder
  function automatic int model(input logic [31:0] sh, input int i);
    int sz[3]; int ordv[3]; int p[3]; int v[3]; int skipax; int w; int r;
    if (sh == 0) return i;
    sz[0] = int'(sh[5:0]) + 1; sz[1] = int'(sh[11:6]) + 1; sz[2] = int'(sh[17:12]) + 1;
    case (sh[20:18])
      3'd0: ordv = '{0, 1, 2};
      3'd1: ordv = '{0, 2, 1};
      3'd2: ordv = '{1, 0, 2};
      3'd3: ordv = '{1, 2, 0};
      3'd4: ordv = '{2, 0, 1};
      default: ordv = '{2, 1, 0};
    endcase
    p[0] = i % sz[ordv[0]];
    p[1] = (i / sz[ordv[0]]) % sz[ordv[1]];
    p[2] = (i / (sz[ordv[0]] * sz[ordv[1]])) % sz[ordv[2]];
    for (int k = 0; k < 3; k++)
      v[ordv[k]] = sh[21 + ordv[k]] ? sz[ordv[k]] - 1 - p[k] : p[k];
    skipax = (sh[29:28] == 0) ? -1 : ordv[int'(sh[29:28]) - 1];
    w = 1;
    r = int'(sh[27:24]);
    for (int a = 0; a < 3; a++) begin
      if (a != skipax) begin
        r += v[a] * w;
        w *= sz[a];
      end
    end
    return r;
  endfunction

  task automatic do_start(input logic [31:0] sh, input int vl);
    @(negedge clk);
    shape = sh; vlen = 7'(vl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_seq(input logic [31:0] sh, input int vl, input string req);
    do_start(sh, vl);
    for (int k = 0; k < vl; k++) begin
      chk(ready === 1'b1, req, int'(ready), 1);
      chk(int'(index) == model(sh, k), req, int'(index), model(sh, k));
      got[k] = int'(index);
      valid = 1'b1;
      @(negedge clk);
    end
    valid = 1'b0;
    chk(done === 1'b1, req, int'(done), 1);
    chk(ready === 1'b0, req, int'(ready), 0);
  endtask

  task automatic t_reset;   // R11
    chk(ready === 1'b0, "R11", int'(ready), 0);
    chk(done === 1'b0, "R11", int'(done), 0);
    chk(idxm === 1'b0, "R11", int'(idxm), 0);
  endtask

  task automatic t_linear;  // R1
    run_seq('0, 5, "R1");
    for (int k = 0; k < 5; k++) chk(got[k] == k, "R1", got[k], k);
  endtask

  task automatic t_plain;   // R2
    run_seq(mk(0, 0, 0, 0, 0, 1, 2), 6, "R2");
    for (int k = 0; k < 6; k++) chk(got[k] == k, "R2", got[k], k);
    run_seq(mk(0, 0, 0, 0, 1, 2, 1), 12, "R2");
  endtask

  task automatic t_orders;  // R3
    int tr[6] = '{0, 3, 1, 4, 2, 5};
    run_seq(mk(0, 0, 0, 2, 0, 1, 2), 6, "R3");
    for (int k = 0; k < 6; k++) chk(got[k] == tr[k], "R3", got[k], tr[k]);
    for (int pm = 0; pm < 6; pm++) run_seq(mk(0, 0, 0, pm, 1, 2, 1), 12, "R3");
  endtask

  task automatic t_invert;  // R4
    int rv[3] = '{2, 1, 0};
    run_seq(mk(0, 0, 1, 0, 0, 0, 2), 3, "R4");
    for (int k = 0; k < 3; k++) chk(got[k] == rv[k], "R4", got[k], rv[k]);
    for (int iv = 1; iv < 8; iv++) run_seq(mk(0, 0, iv, 5, 2, 1, 1), 12, "R4");
  endtask

  task automatic t_skip;    // R5
    int rp[9] = '{0, 0, 0, 1, 1, 1, 2, 2, 2};
    int md[9] = '{0, 1, 2, 0, 1, 2, 0, 1, 2};
    run_seq(mk(1, 0, 0, 0, 0, 2, 2), 9, "R5");
    for (int k = 0; k < 9; k++) chk(got[k] == rp[k], "R5", got[k], rp[k]);
    run_seq(mk(2, 0, 0, 0, 0, 2, 2), 9, "R5");
    for (int k = 0; k < 9; k++) chk(got[k] == md[k], "R5", got[k], md[k]);
    for (int sk = 1; sk < 4; sk++) run_seq(mk(sk, 0, 2, 3, 1, 2, 1), 12, "R5");
  endtask

  task automatic t_offset;  // R6
    run_seq(mk(0, 15, 0, 0, 0, 0, 3), 4, "R6");
    for (int k = 0; k < 4; k++) chk(got[k] == k + 15, "R6", got[k], k + 15);
    run_seq(mk(3, 7, 4, 1, 2, 1, 2), 18, "R6");
  endtask

  task automatic t_indexed; // R7
    for (int pm = 6; pm < 8; pm++) begin
      do_start(mk(0, 0, 0, pm, 0, 1, 1), 4);
      chk(idxm === 1'b1, "R7", int'(idxm), 1);
      chk(done === 1'b1, "R7", int'(done), 1);
      chk(ready === 1'b0, "R7", int'(ready), 0);
    end
  endtask

  task automatic t_stall;   // R8
    logic [31:0] sh = mk(0, 0, 0, 0, 0, 0, 3);
    do_start(sh, 4);
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        chk(ready === 1'b1, "R8", int'(ready), 1);
        chk(int'(index) == k, "R8", int'(index), k);
      end
      valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
    end
    chk(done === 1'b1, "R8", int'(done), 1);
  endtask

  task automatic t_length;  // R9
    do_start(mk(0, 0, 0, 0, 0, 1, 1), 0);
    chk(done === 1'b1 && ready === 1'b0, "R9", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R9", int'(done), 1);
    run_seq(mk(0, 0, 0, 0, 0, 2, 1), 127, "R9");
    chk(got[126] == model(mk(0, 0, 0, 0, 0, 2, 1), 126), "R9", got[126], 0);
    chk(got[6] == 0, "R9", got[6], 0);
  endtask

  task automatic t_restart; // R10
    do_start(mk(0, 0, 0, 0, 0, 2, 2), 9);
    valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(int'(index) == 2, "R10", int'(index), 2);
    run_seq(mk(0, 4, 7, 2, 0, 2, 2), 9, "R10");
    chk(idxm === 1'b0, "R10", int'(idxm), 0);
  endtask

  task automatic finish_sim;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        finish_sim();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_plain();
    t_orders();
    t_invert();
    t_skip();
    t_offset();
    t_indexed();
    t_stall();
    t_length();
    t_restart();
    finish_sim();
  end
endmodule